// File: doc/BRIEF.md
# DMA Channel Register File with Interrupt Coalescing

This block is the control and status register front end of a two-channel scatter-gather DMA engine. A simple 32-bit register bus with read and write strobes reaches two identical channel windows. Each window holds a control word, a status word, a current-descriptor pointer and a tail-descriptor pointer. Channel 0 serves the transmit direction and channel 1 the receive direction.

The data engines report each finished packet with a one-cycle pulse per channel. The block does not raise an interrupt for every packet. A per-channel counter counts completions down from a programmable threshold and raises a completion interrupt when it reaches zero. A per-channel delay timer runs on an external prescaler tick and is restarted by every completion. When the timer runs out, it raises a timeout interrupt and reloads the counter. As a result, a trickle of packets is still reported within a bounded time.

The block also gives the engines their run, idle and halted state, and a one-cycle start pulse when software writes the transmit tail pointer.

Top module: `dmac_regfile`

## Requirements
- R1: After synchronous reset, each channel's control register reads 0x0001_0002 (threshold 1, tail-pointer mode bit 1 reads as 1). Its status register reads 0x0001_0001: halted in bit 0, counter value 1 in bits 23:16, timer 0 in bits 31:24. All irq, run and tx_start outputs are 0.
- R2: The channel is selected by bit 0 of (address / 48). The register is selected by address mod 48: 0x00 control, 0x04 status, 0x08 current descriptor, 0x10 tail descriptor. Reads of any other offset return 0, and writes to them change nothing. The current-descriptor register stores and returns the full 32-bit word.
- R3: Control bit 1 (tail-pointer mode) always reads as 1. The other written control bits are kept, except bit 2. Bit 0 is run/stop and drives the `run` output.
- R4: A control write with bit 2 set is a soft reset. It also counts as a soft reset while bit 2 of the previous write is still pending. A soft reset sets the control register to threshold 1 with all other fields zero, sets status to halted only, and clears the timer. Bit 2 reads as 1 for one cycle and then clears itself. The run bit of that same write is not honoured.
- R5: A control write with bit 0 set and no soft reset clears the halted bit (status bit 0) and the idle bit (status bit 1).
- R6: In a status write, a 1 in any of bits 14:12 clears that bit and a 0 leaves it unchanged. Bits 15 and 11:0 take the written value. If a hardware event sets an interrupt bit in the same cycle, the set wins.
- R7: Channel irq is 1 exactly when some status bit in 14:12 is set and the control bit at the same position is also set. Control bits 14:12 are the enables.
- R8: Every control write reloads the coalescing counter from control bits 23:16.
- R9: Each completion pulse decrements the counter. A pulse that takes the counter from 1 to 0 sets status bit 12 and reloads the counter from the threshold.
- R10: A completion pulse restarts the delay timer from control bits 31:24 when that field is nonzero. When the field is zero, the timer is left as it is.
- R11: A running timer (nonzero) decrements only on cycles where `tick` is high. A tick that takes it from 1 to 0 sets status bit 13 and reloads the counter from the threshold.
- R12: A status read returns the live counter in bits 23:16 and the live timer in bits 31:24, above the stored bits 15:0.
- R13: A tail write stores the pointer and clears the idle bit. On channel 0 only, it also drives `tx_start` high for exactly the one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; when low, bus_rdata is 0 |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pkt_done | input | 2 | Per-channel packet-complete pulse |
| tick | input | 1 | Prescaler tick for the delay timers |
| irq | output | 2 | Per-channel interrupt |
| run | output | 2 | Per-channel run/stop bit |
| idle | output | 2 | Per-channel idle status bit |
| halted | output | 2 | Per-channel halted status bit |
| tx_start | output | 1 | Start pulse to the transmit engine |

## Verification
Coalescing is driven with a bare run of completions against a threshold of 3. It is then driven with completions spaced between ticks and a nonzero delay, and again with a zero delay. Together these separate counter expiry, timer expiry and timer restart. A tick stream with the timer stopped, and a completion that lands while a status write clears the same bit, show that ticks alone change nothing and that a hardware set beats a software clear. Aliased addresses and an unmapped offset check the window decode.

// File: rtl/dmac_pkg.sv
// Shared constants and types for the DMA channel register file.
// Assumes 32-bit registers and 8-bit threshold/delay fields.
package dmac_pkg;
    localparam int DATA_W    = 32;
    localparam int FLD_W     = 8;
    localparam int WIN_BYTES = 48;
    localparam int NCH       = 2;

    // Control bit positions
    localparam int CTL_RUN   = 0;
    localparam int CTL_TMODE = 1;
    localparam int CTL_SRST  = 2;
    localparam int CTL_TH_LO = 16;
    localparam int CTL_DL_LO = 24;

    // Status bit positions
    localparam int ST_HALT   = 0;
    localparam int ST_IDLE   = 1;
    localparam int ST_IOC    = 12;
    localparam int ST_DLY    = 13;
    localparam int ST_GRP_LO = 12;
    localparam int ST_GRP_HI = 14;

    localparam logic [DATA_W-1:0] CTRL_INIT = 32'h0001_0002;
    localparam logic [15:0]       STAT_INIT = 16'h0001;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_CUR,
        SEL_TAIL
    } reg_sel_e;
endpackage

// File: rtl/dmac_addr_dec.sv
// Address decoder: splits a byte address into a channel index and a register select.
// Assumes ADDR_W is at least 6 so that a full window fits.
module dmac_addr_dec
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              ch,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WIN_BYTES);

    logic [ADDR_W-1:0] win_idx;
    logic [ADDR_W-1:0] ofs;

    // Window index and offset inside the window
    always_comb begin
        win_idx = addr / WIN;
        ofs     = addr % WIN;
        ch      = win_idx[0];
    end

    // Map the window offset to a register
    always_comb begin
        case (ofs)
            ADDR_W'(8'h00): sel = SEL_CTRL;
            ADDR_W'(8'h04): sel = SEL_STAT;
            ADDR_W'(8'h08): sel = SEL_CUR;
            ADDR_W'(8'h10): sel = SEL_TAIL;
            default:        sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/dmac_coalesce.sv
// Interrupt coalescing counter and delay timer for one channel.
// Produces single-cycle completion and timeout events for the status register.
// Assumes pkt_done and tick are one-cycle pulses in the clk domain.
module dmac_coalesce #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic [CW-1:0] reload_val,
    input  logic [CW-1:0] thresh,
    input  logic [CW-1:0] delay,
    input  logic          tmr_clr,
    input  logic          pkt_done,
    input  logic          tick,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] tmr,
    output logic          ioc_evt,
    output logic          dly_evt
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] tmr_q;
    logic          restart;

    // Event decode from the current counter and timer state
    always_comb begin
        restart = pkt_done && (delay != '0);
        ioc_evt = pkt_done && !reload && (cnt_q == CW'(1));
        dly_evt = tick && !restart && !tmr_clr && (tmr_q == CW'(1));
    end

    // Coalescing counter: reload, expire or decrement
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= CW'(1);
        else if (reload)              cnt_q <= reload_val;
        else if (ioc_evt || dly_evt)  cnt_q <= thresh;
        else if (pkt_done)            cnt_q <= cnt_q - CW'(1);
    end

    // Delay timer: restart on completion, count down on prescaler tick
    always_ff @(posedge clk) begin
        if (!rst_n)                        tmr_q <= '0;
        else if (tmr_clr)                  tmr_q <= '0;
        else if (restart)                  tmr_q <= delay;
        else if (tick && tmr_q != '0)      tmr_q <= tmr_q - CW'(1);
    end

    assign cnt = cnt_q;
    assign tmr = tmr_q;
endmodule

// File: rtl/dmac_chan.sv
// One DMA channel's registers: control, status, current and tail pointers,
// with the coalescing logic and the interrupt output.
// Assumes wr_hit is already qualified by the channel decode.
module dmac_chan
    import dmac_pkg::*;
#(
    parameter bit HAS_START = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pkt_done,
    input  logic              tick,
    output logic [DATA_W-1:0] ctrl,
    output logic [15:0]       stat,
    output logic [DATA_W-1:0] cur,
    output logic [DATA_W-1:0] tail,
    output logic [FLD_W-1:0]  cnt,
    output logic [FLD_W-1:0]  tmr,
    output logic              irq,
    output logic              start
);
    logic [DATA_W-1:0] ctrl_q, cur_q, tail_q;
    logic [15:0]       stat_q, stat_d;
    logic              wr_ctrl, wr_stat, wr_cur, wr_tail, srst_wr, go_wr;
    logic [FLD_W-1:0]  reload_val;
    logic              ioc_evt, dly_evt;

    // Write qualifiers for this channel
    always_comb begin
        wr_ctrl    = wr_hit && (sel == SEL_CTRL);
        wr_stat    = wr_hit && (sel == SEL_STAT);
        wr_cur     = wr_hit && (sel == SEL_CUR);
        wr_tail    = wr_hit && (sel == SEL_TAIL);
        srst_wr    = wr_ctrl && (wdata[CTL_SRST] || ctrl_q[CTL_SRST]);
        go_wr      = wr_ctrl && wdata[CTL_RUN] && !srst_wr;
        reload_val = srst_wr ? FLD_W'(1) : wdata[CTL_TH_LO +: FLD_W];
    end

    // Control register with forced tail mode and self-clearing soft reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_INIT;
        else if (srst_wr)
            ctrl_q <= CTRL_INIT | (DATA_W'(1) << CTL_SRST);
        else if (wr_ctrl)
            ctrl_q <= {wdata[DATA_W-1:3], 1'b0, 1'b1, wdata[CTL_RUN]};
        else if (ctrl_q[CTL_SRST])
            ctrl_q[CTL_SRST] <= 1'b0;
    end

    // Next status: software writes, run/tail side effects, hardware sets last
    always_comb begin
        stat_d = stat_q;
        if (srst_wr) begin
            stat_d = STAT_INIT;
        end else begin
            if (wr_stat) begin
                stat_d[15]   = wdata[15];
                stat_d[11:0] = wdata[11:0];
                stat_d[ST_GRP_HI:ST_GRP_LO] = stat_q[ST_GRP_HI:ST_GRP_LO]
                                            & ~wdata[ST_GRP_HI:ST_GRP_LO];
            end
            if (go_wr) begin
                stat_d[ST_HALT] = 1'b0;
                stat_d[ST_IDLE] = 1'b0;
            end
            if (wr_tail) stat_d[ST_IDLE] = 1'b0;
            if (ioc_evt) stat_d[ST_IOC]  = 1'b1;
            if (dly_evt) stat_d[ST_DLY]  = 1'b1;
        end
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= STAT_INIT;
        else        stat_q <= stat_d;
    end

    // Descriptor pointer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            tail_q <= '0;
        end else begin
            if (wr_cur)  cur_q  <= wdata;
            if (wr_tail) tail_q <= wdata;
        end
    end

    dmac_coalesce #(.CW(FLD_W)) u_coal (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (wr_ctrl),
        .reload_val (reload_val),
        .thresh     (ctrl_q[CTL_TH_LO +: FLD_W]),
        .delay      (ctrl_q[CTL_DL_LO +: FLD_W]),
        .tmr_clr    (srst_wr),
        .pkt_done   (pkt_done),
        .tick       (tick),
        .cnt        (cnt),
        .tmr        (tmr),
        .ioc_evt    (ioc_evt),
        .dly_evt    (dly_evt)
    );

    // Start pulse only on the transmit channel
    generate
        if (HAS_START) begin : g_start
            logic start_q;
            // One-cycle pulse after a tail write
            always_ff @(posedge clk) begin
                if (!rst_n) start_q <= 1'b0;
                else        start_q <= wr_tail;
            end
            assign start = start_q;
        end else begin : g_nostart
            assign start = 1'b0;
        end
    endgenerate

    assign irq  = |(stat_q[ST_GRP_HI:ST_GRP_LO] & ctrl_q[ST_GRP_HI:ST_GRP_LO]);
    assign ctrl = ctrl_q;
    assign stat = stat_q;
    assign cur  = cur_q;
    assign tail = tail_q;
endmodule

// File: rtl/dmac_regfile.sv
// Top: two-channel DMA register file with interrupt coalescing.
// Decodes the register bus, instantiates one channel block per channel and
// muxes read data. Assumes single-cycle read/write strobes; read data is combinational.
module dmac_regfile
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    pkt_done,
    input  logic              tick,
    output logic [NCH-1:0]    irq,
    output logic [NCH-1:0]    run,
    output logic [NCH-1:0]    idle,
    output logic [NCH-1:0]    halted,
    output logic              tx_start
);
    logic     dec_ch;
    reg_sel_e dec_sel;

    logic [NCH-1:0][DATA_W-1:0] ctrl_all, cur_all, tail_all;
    logic [NCH-1:0][15:0]       stat_all;
    logic [NCH-1:0][FLD_W-1:0]  cnt_all, tmr_all;
    logic [NCH-1:0]             start_v;

    dmac_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .ch   (dec_ch),
        .sel  (dec_sel)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            logic wr_hit;
            assign wr_hit = bus_wr && (dec_ch == 1'(i));

            dmac_chan #(.HAS_START(i == 0)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_hit   (wr_hit),
                .sel      (dec_sel),
                .wdata    (bus_wdata),
                .pkt_done (pkt_done[i]),
                .tick     (tick),
                .ctrl     (ctrl_all[i]),
                .stat     (stat_all[i]),
                .cur      (cur_all[i]),
                .tail     (tail_all[i]),
                .cnt      (cnt_all[i]),
                .tmr      (tmr_all[i]),
                .irq      (irq[i]),
                .start    (start_v[i])
            );

            assign run[i]    = ctrl_all[i][CTL_RUN];
            assign idle[i]   = stat_all[i][ST_IDLE];
            assign halted[i] = stat_all[i][ST_HALT];
        end
    endgenerate

    // Read mux: live counter and timer overlay the stored status bits
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (dec_sel)
                SEL_CTRL: bus_rdata = ctrl_all[dec_ch];
                SEL_STAT: bus_rdata = {tmr_all[dec_ch], cnt_all[dec_ch], stat_all[dec_ch]};
                SEL_CUR:  bus_rdata = cur_all[dec_ch];
                SEL_TAIL: bus_rdata = tail_all[dec_ch];
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign tx_start = |start_v;
endmodule

// File: rtl/dmac_regfile_chk.sv
// Assertion checker for dmac_regfile, attached with bind.
// Observes ports plus per-channel state slices taken from the top.
module dmac_regfile_chk
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NCH-1:0]    pkt_done,
    input logic              tick,
    input logic              tx_start,
    input logic [NCH-1:0]    irq,
    input logic [NCH-1:0]    halted,
    input logic [NCH-1:0]    run,
    input logic [NCH-1:0]    srst_pend,
    input logic [NCH-1:0]    ioc_bit,
    input logic [NCH-1:0][2:0] irq_grp,
    input logic [NCH-1:0][FLD_W-1:0] cnt_all,
    input logic [NCH-1:0][FLD_W-1:0] tmr_all
);
    logic     c_ch;
    reg_sel_e c_sel;

    dmac_addr_dec #(.ADDR_W(ADDR_W)) u_cdec (
        .addr (bus_addr),
        .ch   (c_ch),
        .sel  (c_sel)
    );

    // Reset leaves every channel halted with no interrupt
    assert_reset_halted_R1: assert property (@(posedge clk)
        !rst_n |=> (halted == '1) && (irq == '0));

    // Only a channel-0 tail write produces a start pulse
    assert_start_from_tail_R13: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(bus_wr && c_ch == 1'b0 && c_sel == SEL_TAIL));

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_a
            logic wr_ch;
            assign wr_ch = bus_wr && (c_ch == 1'(i));

            // Soft reset pending bit clears itself
            assert_srst_selfclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                srst_pend[i] && !(wr_ch && c_sel == SEL_CTRL) |=> !srst_pend[i]);

            // While soft reset is pending the channel is halted and stopped
            assert_srst_halted_R4: assert property (@(posedge clk) disable iff (!rst_n)
                srst_pend[i] |-> halted[i] && !run[i]);

            // A completion taking the counter to zero sets the completion bit
            assert_ioc_on_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
                pkt_done[i] && cnt_all[i] == FLD_W'(1) && !(wr_ch && c_sel == SEL_CTRL)
                |=> ioc_bit[i]);

            // Completion bit stays set until a register write
            assert_ioc_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
                ioc_bit[i] && !bus_wr |=> ioc_bit[i]);

            // Timer only moves on tick, completion or a write
            assert_timer_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
                !tick && !pkt_done[i] && !bus_wr |=> $stable(tmr_all[i]));

            // An interrupt needs a pending status bit
            assert_irq_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
                irq[i] |-> (irq_grp[i] != 3'b000));
        end
    endgenerate
endmodule

bind dmac_regfile dmac_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .pkt_done  (pkt_done),
    .tick      (tick),
    .tx_start  (tx_start),
    .irq       (irq),
    .halted    (halted),
    .run       (run),
    .srst_pend ({ctrl_all[1][2], ctrl_all[0][2]}),
    .ioc_bit   ({stat_all[1][12], stat_all[0][12]}),
    .irq_grp   ({stat_all[1][14:12], stat_all[0][14:12]}),
    .cnt_all   (cnt_all),
    .tmr_all   (tmr_all)
);

// File: tb/sim_dmac_regfile.sv
`timescale 1ns/1ps
// Directed bench for dmac_regfile; one task per scenario.
module sim_dmac_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pkt_done = '0;
    logic        tick = 1'b0;
    logic [1:0]  irq, run, idle, halted;
    logic        tx_start;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dmac_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pkt_done(pkt_done), .tick(tick), .irq(irq), .run(run),
        .idle(idle), .halted(halted), .tx_start(tx_start)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic pulse_done(input int ch);
        @(negedge clk);
        pkt_done[ch] = 1'b1;
        @(negedge clk);
        pkt_done = '0;
    endtask

    task automatic pulse_tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        check("R1 halted", 32'(halted), 32'h3);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 run", 32'(run), 32'h0);
        check("R1 tx_start", 32'(tx_start), 32'h0);
        rd_chk("R1 ctrl ch0", 8'h00, 32'h0001_0002);
        rd_chk("R1 stat ch0", 8'h04, 32'h0001_0001);
        rd_chk("R1 ctrl ch1", 8'h30, 32'h0001_0002);
        rd_chk("R1 stat ch1", 8'h34, 32'h0001_0001);
    endtask

    task automatic t_decode;
        wr(8'h08, 32'hA5A5_0000);
        wr(8'h38, 32'h1234_5678);
        rd_chk("R2 cur ch0", 8'h08, 32'hA5A5_0000);
        rd_chk("R2 cur ch1", 8'h38, 32'h1234_5678);
        rd_chk("R2 alias ch0", 8'h68, 32'hA5A5_0000);
        rd_chk("R2 alias ch1", 8'h98, 32'h1234_5678);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_chk("R2 unmapped read", 8'h0C, 32'h0);
        rd_chk("R2 unmapped write ignored", 8'h08, 32'hA5A5_0000);
        rd_chk("R2 unmapped ctrl kept", 8'h00, 32'h0001_0002);
    endtask

    task automatic t_run;
        wr(8'h04, 32'h0000_0003);
        check("R6 idle set by write", 32'(idle[0]), 32'h1);
        rd_chk("R6 stat written", 8'h04, 32'h0001_0003);
        wr(8'h00, 32'h0000_0001);
        rd_chk("R3 tailmode forced", 8'h00, 32'h0000_0003);
        check("R5 run out", 32'(run), 32'h1);
        check("R5 halted cleared", 32'(halted), 32'h2);
        check("R5 idle cleared", 32'(idle[0]), 32'h0);
        rd_chk("R8 reload to 0", 8'h04, 32'h0000_0000);
    endtask

    task automatic t_srst;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'hFF00_7005;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b1; #1;
        check("R4 srst pending", bus_rdata, 32'h0001_0006);
        bus_rd = 1'b0;
        check("R4 run ignored", 32'(run[0]), 32'h0);
        check("R4 halted", 32'(halted[0]), 32'h1);
        rd_chk("R4 selfclear", 8'h00, 32'h0001_0002);
        rd_chk("R4 stat", 8'h04, 32'h0001_0001);
    endtask

    task automatic t_coalesce;
        wr(8'h30, 32'h0003_1001);
        rd_chk("R8 cnt=3", 8'h34, 32'h0003_0000);
        pulse_done(1);
        rd_chk("R9 cnt=2", 8'h34, 32'h0002_0000);
        pulse_done(1);
        rd_chk("R9 cnt=1", 8'h34, 32'h0001_0000);
        check("R7 no irq yet", 32'(irq[1]), 32'h0);
        pulse_done(1);
        rd_chk("R9 ioc + reload", 8'h34, 32'h0003_1000);
        check("R7 irq set", 32'(irq[1]), 32'h1);
        wr(8'h34, 32'h0000_0000);
        rd_chk("R6 zero keeps ioc", 8'h34, 32'h0003_1000);
        wr(8'h34, 32'h0000_1000);
        rd_chk("R6 w1c", 8'h34, 32'h0003_0000);
        check("R7 irq cleared", 32'(irq[1]), 32'h0);
        pulse_done(1);
        pulse_done(1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h34; bus_wdata = 32'h0000_1000; pkt_done[1] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; pkt_done = '0;
        rd_chk("R6 set beats clear", 8'h34, 32'h0003_1000);
        wr(8'h30, 32'h0003_0001);
        check("R7 enable off", 32'(irq[1]), 32'h0);
        wr(8'h30, 32'h0003_1001);
        check("R7 enable on", 32'(irq[1]), 32'h1);
        wr(8'h34, 32'h0000_7000);
        pulse_done(1);
        rd_chk("R8 pre", 8'h34, 32'h0002_0000);
        wr(8'h30, 32'h0005_0001);
        rd_chk("R8 reload", 8'h34, 32'h0005_0000);
    endtask

    task automatic t_delay;
        wr(8'h00, 32'h0405_2001);
        rd_chk("R3 ctrl delay", 8'h00, 32'h0405_2003);
        pulse_tick(2);
        rd_chk("R11 idle timer", 8'h04, 32'h0005_0000);
        pulse_done(0);
        rd_chk("R10 start", 8'h04, 32'h0404_0000);
        pulse_tick(2);
        rd_chk("R12 timer live", 8'h04, 32'h0204_0000);
        pulse_done(0);
        rd_chk("R10 restart", 8'h04, 32'h0403_0000);
        pulse_tick(3);
        rd_chk("R11 timer=1", 8'h04, 32'h0103_0000);
        check("R11 no irq yet", 32'(irq[0]), 32'h0);
        pulse_tick(1);
        rd_chk("R11 expire", 8'h04, 32'h0005_2000);
        check("R11 irq", 32'(irq[0]), 32'h1);
        wr(8'h04, 32'h0000_2000);
        check("R6 dly cleared", 32'(irq[0]), 32'h0);
        wr(8'h00, 32'h0002_0001);
        pulse_done(0);
        rd_chk("R10 zero delay", 8'h04, 32'h0001_0000);
    endtask

    task automatic t_tail;
        wr(8'h34, 32'h0000_0002);
        check("R13 ch1 idle set", 32'(idle[1]), 32'h1);
        wr(8'h40, 32'h0000_0400);
        check("R13 ch1 no start", 32'(tx_start), 32'h0);
        check("R13 ch1 idle clr", 32'(idle[1]), 32'h0);
        rd_chk("R13 ch1 tail", 8'h40, 32'h0000_0400);
        wr(8'h04, 32'h0000_0002);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h0000_0800;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R13 start high", 32'(tx_start), 32'h1);
        check("R13 ch0 idle clr", 32'(idle[0]), 32'h0);
        @(negedge clk);
        check("R13 start one cycle", 32'(tx_start), 32'h0);
        rd_chk("R13 ch0 tail", 8'h10, 32'h0000_0800);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_run();
        t_srst();
        t_coalesce();
        t_delay();
        t_tail();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule